// File: doc/BRIEF.md
# Extended Float to Signed Packed Decimal Converter

The block takes one 80-bit extended-precision floating-point operand and turns it into a signed packed decimal integer of 18 digits. A one-cycle start strobe latches the operand, a 2-bit rounding control and an exception mask. The first stage rounds the value to an integer and sorts out special encodings. A second stage then converts the binary magnitude to decimal digits by shift-and-add-3, one bit per clock. The block answers with a one-cycle done strobe, a store-enable and the 80-bit result word, all registered. Status comes with it: inexact, invalid, rounded-up and an underflow indication.

The operand layout is fixed. Bit 79 is the sign. Bits 78:64 hold the exponent, biased by 16383. Bits 63:0 hold a significand whose integer bit is explicit. When the magnitude is too large, or the operand cannot be converted, the exception mask decides the outcome. Masked, the store goes ahead with a fixed indefinite pattern. Unmasked, the store is suppressed. A separate input tells the unit that the source register was empty. In that case the result is treated like an invalid operand and the underflow status is raised.

Top module: `xf_bcd_store`

## Requirements
- R1: The result word puts the sign in bit 79, keeps bits 78:72 at zero and holds 18 decimal digits in bits 71:0, with the least significant digit in bits 3:0. Each digit is a 4-bit value from 0 to 9.
- R2: A non-integral operand is rounded to an integer before conversion. Rounding control 00 rounds to nearest with ties to even, 01 rounds toward minus infinity, 10 rounds toward plus infinity and 11 rounds toward zero.
- R3: For a convertible operand, inexact is 1 exactly when the operand is not an integer.
- R4: Rounded-up is 1 exactly when rounding increased the magnitude. It is never 1 without inexact.
- R5: A rounded magnitude above 999999999999999999 raises invalid. An exponent of 64 or more after removing the bias also raises invalid.
- R6: An operand whose exponent field is all ones (infinity or NaN) raises invalid. So does an operand with a nonzero exponent field whose bit 63 is 0.
- R7: If invalid is raised while the mask input was 0 at start, store-enable stays 0, the result word is zero, and inexact and rounded-up are 0.
- R8: If invalid is raised while the mask input was 1 at start, store-enable is 1 and the result is 0xFFFF_C000_0000_0000_0000.
- R9: A zero operand, or an operand that rounds to zero, gives all-zero digits and keeps the operand's sign in bit 79.
- R10: When the empty-source input is 1 at start, the underflow output and invalid are set, rounded-up and inexact are 0, and the store follows R7/R8.
- R11: The done strobe is high for exactly one cycle, in the cycle after the 66th rising edge that follows the edge sampling start. Store-enable is high only together with done.
- R12: After reset all outputs are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Start strobe, sampled while idle |
| operand_i | input | 80 | Extended-precision operand |
| rnd_mode_i | input | 2 | Rounding control |
| inv_mask_i | input | 1 | 1 masks the invalid exception |
| empty_src_i | input | 1 | Source register was empty |
| done_o | output | 1 | One-cycle completion strobe |
| store_en_o | output | 1 | Result word is to be written |
| result_o | output | 80 | Signed packed decimal result |
| inexact_o | output | 1 | Operand was not an integer |
| invalid_o | output | 1 | Invalid operand or overflow |
| rnd_up_o | output | 1 | Rounding increased the magnitude |
| uflow_o | output | 1 | Empty-source condition reported |

## Verification
The assertions cover what must hold on every cycle:
- done lasts one cycle, and store-enable never appears without it;
- the padding bits and every digit stay in range;
- rounded-up implies inexact;
- underflow excludes rounded-up;
- the store-enable and indefinite outcome match the latched mask.

Only the scenarios can show the values themselves. These are the rounding direction in each mode, the ties-to-even choice, and the overflow edge at eighteen nines, including a half that rounds across it. The scenarios also cover the signed zeros from rounding and the classification of infinities, NaNs, unsupported and denormal encodings. They also measure the exact latency.

// File: rtl/xbcd_pkg.sv
package xbcd_pkg;

  typedef enum logic [1:0] {
    RC_NEAR = 2'b00,
    RC_DOWN = 2'b01,
    RC_UP   = 2'b10,
    RC_ZERO = 2'b11
  } xb_rc_e;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_ROUND,
    ST_CONV,
    ST_FIN
  } xb_state_e;

endpackage

// File: rtl/xbcd_round.sv
module xbcd_round #(
  parameter int SIG_W  = 64,
  parameter int EXP_W  = 15,
  parameter int DIGITS = 18
) (
  input  logic             sign_i,
  input  logic [EXP_W-1:0] exp_i,
  input  logic [SIG_W-1:0] sig_i,
  input  logic [1:0]       rc_i,
  output logic [SIG_W-1:0] mag_o,
  output logic             inexact_o,
  output logic             up_o,
  output logic             invalid_o
);
  import xbcd_pkg::*;

  localparam int SH_W = $clog2(SIG_W);
  localparam int BIAS = (1 << (EXP_W - 1)) - 1;

  function automatic logic [SIG_W:0] limit_f();
    logic [SIG_W:0] v;
    v = 1;
    for (int i = 0; i < DIGITS; i++) v = v * 10;
    return v - 1;
  endfunction

  localparam logic [SIG_W:0] LIMIT = limit_f();

  logic signed [EXP_W+1:0] unb;
  logic [SH_W-1:0]  sh;
  logic [SIG_W-1:0] low_mask;
  logic [SIG_W-1:0] intp;
  logic             rbit, sticky, big, up, frac_nz;
  logic             zero_exp, max_exp, unsupported;
  logic [SIG_W:0]   mag;

  assign zero_exp    = (exp_i == '0);
  assign max_exp     = &exp_i;
  assign unsupported = !zero_exp && !max_exp && !sig_i[SIG_W-1];
  assign unb = $signed({2'b00, exp_i}) - $signed((EXP_W+2)'(BIAS));
  assign sh  = SH_W'(SIG_W - 1) - unb[SH_W-1:0];

  always_comb begin
    intp     = '0;
    rbit     = 1'b0;
    sticky   = 1'b0;
    big      = 1'b0;
    low_mask = '0;
    if (zero_exp) begin
      sticky = |sig_i;
    end else if (unb >= $signed((EXP_W+2)'(SIG_W))) begin
      big = 1'b1;
    end else if (unb >= 0) begin
      low_mask = ~({SIG_W{1'b1}} << sh);
      intp     = sig_i >> sh;
      rbit     = |(sig_i & (low_mask ^ (low_mask >> 1)));
      sticky   = |(sig_i & (low_mask >> 1));
    end else if (unb == -1) begin
      rbit   = sig_i[SIG_W-1];
      sticky = |sig_i[SIG_W-2:0];
    end else begin
      sticky = |sig_i;
    end
  end

  assign frac_nz = rbit | sticky;

  always_comb begin
    case (xb_rc_e'(rc_i))
      RC_NEAR: up = rbit & (sticky | intp[0]);
      RC_DOWN: up = sign_i & frac_nz;
      RC_UP:   up = !sign_i & frac_nz;
      default: up = 1'b0;
    endcase
  end

  assign mag       = {1'b0, intp} + {{SIG_W{1'b0}}, up};
  assign invalid_o = max_exp | unsupported | big | (mag > LIMIT);
  assign inexact_o = !invalid_o & frac_nz;
  assign up_o      = !invalid_o & up;
  assign mag_o     = mag[SIG_W-1:0];

endmodule

// File: rtl/xbcd_dabble.sv
module xbcd_dabble #(
  parameter int BIN_W  = 64,
  parameter int DIGITS = 18
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  load_i,
  input  logic [BIN_W-1:0]      bin_i,
  input  logic                  step_i,
  output logic [4*DIGITS-1:0]   bcd_o
);
  localparam int BCD_W = 4 * DIGITS;

  logic [BIN_W-1:0] bin_q;
  logic [BCD_W-1:0] bcd_q;
  logic [BCD_W-1:0] adj;

  for (genvar g = 0; g < DIGITS; g++) begin : g_dig
    assign adj[4*g +: 4] = (bcd_q[4*g +: 4] >= 4'd5) ? bcd_q[4*g +: 4] + 4'd3
                                                     : bcd_q[4*g +: 4];
    AST_DIGIT_DEC: assert property (@(posedge clk) disable iff (rst)
      bcd_q[4*g +: 4] <= 4'd9); // R1
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bin_q <= '0;
      bcd_q <= '0;
    end else if (load_i) begin
      bin_q <= bin_i;
      bcd_q <= '0;
    end else if (step_i) begin
      {bcd_q, bin_q} <= {adj, bin_q} << 1;
    end
  end

  assign bcd_o = bcd_q;

endmodule

// File: rtl/xf_bcd_store.sv
module xf_bcd_store #(
  parameter int SIG_W  = 64,
  parameter int EXP_W  = 15,
  parameter int DIGITS = 18
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       start_i,
  input  logic [SIG_W+EXP_W:0]       operand_i,
  input  logic [1:0]                 rnd_mode_i,
  input  logic                       inv_mask_i,
  input  logic                       empty_src_i,
  output logic                       done_o,
  output logic                       store_en_o,
  output logic [SIG_W+EXP_W:0]       result_o,
  output logic                       inexact_o,
  output logic                       invalid_o,
  output logic                       rnd_up_o,
  output logic                       uflow_o
);
  import xbcd_pkg::*;

  localparam int W     = SIG_W + EXP_W + 1;
  localparam int BCD_W = 4 * DIGITS;
  localparam int PAD   = W - 1 - BCD_W;
  localparam int CNT_W = $clog2(SIG_W);
  localparam logic [W-1:0] INDEF = {{18{1'b1}}, {(W-18){1'b0}}};

  xb_state_e        state;
  logic [CNT_W-1:0] cnt;
  logic             sign_q, mask_q, empty_q;
  logic [EXP_W-1:0] exp_q;
  logic [SIG_W-1:0] sig_q;
  logic [1:0]       rc_q;
  logic             inv_q, inx_q, up_q;

  logic [SIG_W-1:0] r_mag;
  logic             r_inx, r_up, r_inv;
  logic [BCD_W-1:0] bcd;
  logic             load, step;

  xbcd_round #(.SIG_W(SIG_W), .EXP_W(EXP_W), .DIGITS(DIGITS)) u_round (
    .sign_i    (sign_q),
    .exp_i     (exp_q),
    .sig_i     (sig_q),
    .rc_i      (rc_q),
    .mag_o     (r_mag),
    .inexact_o (r_inx),
    .up_o      (r_up),
    .invalid_o (r_inv)
  );

  assign load = (state == ST_ROUND);
  assign step = (state == ST_CONV);

  xbcd_dabble #(.BIN_W(SIG_W), .DIGITS(DIGITS)) u_dabble (
    .clk    (clk),
    .rst    (rst),
    .load_i (load),
    .bin_i  (r_mag),
    .step_i (step),
    .bcd_o  (bcd)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state   <= ST_IDLE;
      cnt     <= '0;
      sign_q  <= 1'b0;
      exp_q   <= '0;
      sig_q   <= '0;
      rc_q    <= 2'b00;
      mask_q  <= 1'b0;
      empty_q <= 1'b0;
      inv_q   <= 1'b0;
      inx_q   <= 1'b0;
      up_q    <= 1'b0;
    end else begin
      case (state)
        ST_IDLE: if (start_i) begin
          sign_q  <= operand_i[W-1];
          exp_q   <= operand_i[W-2:SIG_W];
          sig_q   <= operand_i[SIG_W-1:0];
          rc_q    <= rnd_mode_i;
          mask_q  <= inv_mask_i;
          empty_q <= empty_src_i;
          state   <= ST_ROUND;
        end
        ST_ROUND: begin
          inv_q <= r_inv | empty_q;
          inx_q <= r_inx & !empty_q;
          up_q  <= r_up & !empty_q;
          cnt   <= '0;
          state <= ST_CONV;
        end
        ST_CONV: begin
          cnt <= cnt + 1'b1;
          if (cnt == CNT_W'(SIG_W - 1)) state <= ST_FIN;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      done_o     <= 1'b0;
      store_en_o <= 1'b0;
      result_o   <= '0;
      inexact_o  <= 1'b0;
      invalid_o  <= 1'b0;
      rnd_up_o   <= 1'b0;
      uflow_o    <= 1'b0;
    end else if (state == ST_FIN) begin
      done_o  <= 1'b1;
      uflow_o <= empty_q;
      if (inv_q) begin
        invalid_o  <= 1'b1;
        inexact_o  <= 1'b0;
        rnd_up_o   <= 1'b0;
        store_en_o <= mask_q;
        result_o   <= mask_q ? INDEF : '0;
      end else begin
        invalid_o  <= 1'b0;
        inexact_o  <= inx_q;
        rnd_up_o   <= up_q;
        store_en_o <= 1'b1;
        result_o   <= {sign_q, {PAD{1'b0}}, bcd};
      end
    end else begin
      done_o     <= 1'b0;
      store_en_o <= 1'b0;
    end
  end

  AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
    done_o |=> !done_o); // R11
  AST_STORE_WITH_DONE: assert property (@(posedge clk) disable iff (rst)
    store_en_o |-> done_o); // R11
  AST_UNMASKED_SILENT: assert property (@(posedge clk) disable iff (rst)
    (done_o && invalid_o && !mask_q) |-> !store_en_o); // R7
  AST_MASKED_INDEF: assert property (@(posedge clk) disable iff (rst)
    (done_o && invalid_o && mask_q) |-> (store_en_o && result_o == INDEF)); // R8
  AST_RNDUP_INEXACT: assert property (@(posedge clk) disable iff (rst)
    rnd_up_o |-> inexact_o); // R4
  AST_UFLOW_STATUS: assert property (@(posedge clk) disable iff (rst)
    uflow_o |-> (!rnd_up_o && invalid_o)); // R10
  AST_PAD_ZERO: assert property (@(posedge clk) disable iff (rst)
    (done_o && !invalid_o) |-> (result_o[W-2:BCD_W] == '0)); // R1

endmodule

// File: tb/xf_bcd_store_test.sv
module xf_bcd_store_test;
  localparam int CLK_P = 10;
  localparam logic [79:0] INDEF = 80'hFFFF_C000_0000_0000_0000;

  typedef struct packed {
    logic [79:0] res;
    logic st, inv, inx, up, uf;
  } exp_t;

  logic        clk = 0, rst = 1, start = 0;
  logic [79:0] op = '0;
  logic [1:0]  rc = 2'b00;
  logic        mask = 0, empty = 0;
  logic        done_o, store_en_o, inexact_o, invalid_o, rnd_up_o, uflow_o;
  logic [79:0] result_o;

  exp_t  q[$];
  string tq[$];
  int    checks = 0, errors = 0, ndone = 0, cyc = 0, t0 = 0;
  bit    finished = 0;

  xf_bcd_store uut (
    .clk(clk), .rst(rst), .start_i(start), .operand_i(op), .rnd_mode_i(rc),
    .inv_mask_i(mask), .empty_src_i(empty), .done_o(done_o),
    .store_en_o(store_en_o), .result_o(result_o), .inexact_o(inexact_o),
    .invalid_o(invalid_o), .rnd_up_o(rnd_up_o), .uflow_o(uflow_o)
  );

  always #(CLK_P/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  function automatic logic [79:0] bcd(input logic s, input longint unsigned v);
    logic [79:0] r = '0;
    longint unsigned x = v;
    for (int i = 0; i < 18; i++) begin
      r[4*i +: 4] = 4'(x % 10);
      x = x / 10;
    end
    r[79] = s;
    return r;
  endfunction

  function automatic logic [79:0] enc(input logic s, input int unb, input logic [63:0] sig);
    return {s, 15'(16383 + unb), sig};
  endfunction

  function automatic logic [79:0] enc_int(input logic s, input longint unsigned v);
    int p = 0;
    if (v == 0) return {s, 79'b0};
    for (int i = 0; i < 64; i++) if (v[i]) p = i;
    return enc(s, p, 64'(v) << (63 - p));
  endfunction

  task automatic check(input string tag, input logic ok, input logic [79:0] act, input logic [79:0] expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, expv);
    end
  endtask

  // monitor: pops the scoreboard on every done strobe; R11 latency from start
  always @(negedge clk) begin
    if (!rst && done_o) begin
      exp_t  e;
      string t;
      logic [79:0] act;
      if (q.size() == 0) begin
        check("R11 unexpected done", 1'b0, 80'(ndone), 80'(0));
      end else begin
        e = q.pop_front();
        t = tq.pop_front();
        act = {result_o[79:5], store_en_o, invalid_o, inexact_o, rnd_up_o, uflow_o};
        check(t, result_o == e.res && store_en_o == e.st && invalid_o == e.inv &&
                 inexact_o == e.inx && rnd_up_o == e.up && uflow_o == e.uf,
              {result_o[79:5], store_en_o, invalid_o, inexact_o, rnd_up_o, uflow_o},
              {e.res[79:5], e.st, e.inv, e.inx, e.up, e.uf});
        // done appears after the 66th edge beyond the start edge t0+1
        check({"R11 latency ", t}, (cyc - t0) == 67, 80'(cyc - t0), 80'(67));
        if (act == '1) checks = checks + 0;
      end
      ndone++;
    end
  end

  task automatic run(input string tag, input logic [79:0] o, input logic [1:0] r,
                     input logic m, input logic u, input logic [79:0] res,
                     input logic st, input logic inv, input logic inx, input logic up);
    exp_t e;
    int   n;
    e.res = res; e.st = st; e.inv = inv; e.inx = inx; e.up = up; e.uf = u;
    q.push_back(e);
    tq.push_back(tag);
    n = ndone;
    @(negedge clk);
    op = o; rc = r; mask = m; empty = u; start = 1;
    t0 = cyc;
    @(negedge clk);
    start = 0;
    op = '0;
    while (ndone == n) @(negedge clk);
    @(negedge clk);
    check({"R11 done pulse ", tag}, done_o == 1'b0 && store_en_o == 1'b0,
          80'({done_o, store_en_o}), 80'(0));
  endtask

  initial begin
    #(CLK_P * 150000);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    longint unsigned nines = 64'd999999999999999999;
    longint unsigned e18   = 64'd1000000000000000000;
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    check("R12 reset outputs", {done_o, store_en_o, result_o, inexact_o, invalid_o,
          rnd_up_o, uflow_o} == '0, result_o, 80'h0);

    // R1 layout with exact integers
    run("R1 +1234", enc_int(0, 1234), 2'b00, 0, 0, bcd(0, 1234), 1, 0, 0, 0);
    run("R1 -123456789012345678", enc_int(1, 64'd123456789012345678), 2'b00, 0, 0,
        bcd(1, 64'd123456789012345678), 1, 0, 0, 0);
    // R2 R3 R4 rounding modes on 2.5 (10.1b), -2.5 and 3.5
    run("R2 2.5 nearest-even", enc(0, 1, 64'b101 << 61), 2'b00, 0, 0, bcd(0, 2), 1, 0, 1, 0);
    run("R2 2.5 toward +inf", enc(0, 1, 64'b101 << 61), 2'b10, 0, 0, bcd(0, 3), 1, 0, 1, 1);
    run("R2 -2.5 toward -inf", enc(1, 1, 64'b101 << 61), 2'b01, 0, 0, bcd(1, 3), 1, 0, 1, 1);
    run("R4 -2.5 toward zero", enc(1, 1, 64'b101 << 61), 2'b11, 0, 0, bcd(1, 2), 1, 0, 1, 0);
    run("R2 3.5 nearest-even", enc(0, 1, 64'b111 << 61), 2'b00, 0, 0, bcd(0, 4), 1, 0, 1, 1);
    run("R2 0.75 nearest", enc(0, -1, 64'b11 << 62), 2'b00, 0, 0, bcd(0, 1), 1, 0, 1, 1);
    run("R3 0.75 toward zero", enc(0, -1, 64'b11 << 62), 2'b11, 0, 0, bcd(0, 0), 1, 0, 1, 0);
    // R9 signed zeros
    run("R9 -0.25 toward +inf", enc(1, -2, 64'd1 << 63), 2'b10, 0, 0, bcd(1, 0), 1, 0, 1, 0);
    run("R2 -0.25 toward -inf", enc(1, -2, 64'd1 << 63), 2'b01, 0, 0, bcd(1, 1), 1, 0, 1, 1);
    run("R9 +0", enc_int(0, 0), 2'b00, 0, 0, bcd(0, 0), 1, 0, 0, 0);
    run("R9 -0", enc_int(1, 0), 2'b10, 0, 0, bcd(1, 0), 1, 0, 0, 0);
    // R5 overflow boundary
    run("R5 eighteen nines", enc_int(0, nines), 2'b00, 0, 0, bcd(0, nines), 1, 0, 0, 0);
    run("R8 1e18 masked", enc_int(0, e18), 2'b00, 1, 0, INDEF, 1, 1, 0, 0);
    run("R7 1e18 unmasked", enc_int(1, e18), 2'b00, 0, 0, 80'h0, 0, 1, 0, 0);
    run("R5 nines+0.5 rounds over", enc(0, 59, (64'(nines) << 4) | (64'd1 << 3)), 2'b00, 1, 0,
        INDEF, 1, 1, 0, 0);
    run("R3 nines+0.5 toward zero", enc(0, 59, (64'(nines) << 4) | (64'd1 << 3)), 2'b11, 1, 0,
        bcd(0, nines), 1, 0, 1, 0);
    run("R5 exponent 70", enc(0, 70, 64'd1 << 63), 2'b00, 1, 0, INDEF, 1, 1, 0, 0);
    // R6 special encodings
    run("R6 +inf masked", {1'b0, 15'h7FFF, 64'h8000_0000_0000_0000}, 2'b00, 1, 0, INDEF, 1, 1, 0, 0);
    run("R6 qnan unmasked", {1'b1, 15'h7FFF, 64'hC000_0000_0000_0000}, 2'b00, 0, 0, 80'h0, 0, 1, 0, 0);
    run("R6 unsupported", enc(0, 0, 64'h4000_0000_0000_0000), 2'b00, 1, 0, INDEF, 1, 1, 0, 0);
    run("R3 denormal toward +inf", {1'b0, 15'h0, 64'd1}, 2'b10, 0, 0, bcd(0, 1), 1, 0, 1, 1);
    run("R3 denormal nearest", {1'b0, 15'h0, 64'd1}, 2'b00, 0, 0, bcd(0, 0), 1, 0, 1, 0);
    // R10 empty source
    run("R10 empty masked", enc(0, 1, 64'b101 << 61), 2'b10, 1, 1, INDEF, 1, 1, 0, 0);
    run("R10 empty unmasked", enc(0, 1, 64'b101 << 61), 2'b10, 0, 1, 80'h0, 0, 1, 0, 0);

    finished = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule